// File: doc/BRIEF.md
# DMX512 Packet Transmitter

This block produces an endless train of DMX512 packets on one single-ended serial line that an external RS-485 driver turns into the differential signal. Every packet opens with a long space (the break), then a short mark (the mark-after-break), then a start-code slot, then a programmable number of channel slots. Channel values sit in a 512-entry byte store inside the block. The store is loaded through a simple write port.

All timing comes from the system clock through a divider of `CLK_PER_BIT` clocks per bit time (one bit time is 4 µs on the wire, so the default of 200 suits a 50 MHz clock). The slot count, start code, break length and mark-after-break length are configuration inputs. They are captured once, when a packet begins. When a packet is short, the transmitter pads the line with mark so that breaks never come closer than the minimum packet period. Deasserting `enable` lets the current packet run to its end, after which the line rests at mark.

Top module: `dmx_packet_tx`

## Requirements
- R1: After reset, and whenever no packet is in progress, `txOut` is 1 (mark). When `enable` is sampled high at a rising edge while idle, the break begins in the next clock cycle.
- R2: The break holds `txOut` at 0 for `cfgBreakBits` bit times of `CLK_PER_BIT` clocks each. A value below 23 is raised to 23.
- R3: The mark-after-break holds `txOut` at 1 for `cfgMabBits` bit times. A value below 2 is raised to 2.
- R4: Each slot lasts 11 bit times: a 0 start bit, eight data bits sent least significant bit first, then two 1 stop bits. Slots follow one another with no gap. The first slot after the mark-after-break carries the captured start code.
- R5: Channel slots follow the start code in ascending order. Channel slot k (k = 1 upward) carries the store entry at write address k-1. A write takes effect when `memWrEn` is high at a rising edge.
- R6: A slot count of 0 is treated as 1, and a slot count above 512 is treated as 512.
- R7: Consecutive breaks start at least 301 bit times apart. After the last slot the line is held at mark until 301 bit times have passed since the break began. A packet that is already longer gets no padding.
- R8: The four configuration inputs are captured only in the cycle a packet begins. Changing them during a packet has no effect on that packet.
- R9: If `enable` is high when a packet ends, the next break begins in the very next cycle, with freshly captured configuration. If it is low, the packet finishes in full and the line then stays at mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Keep sending packets while high |
| cfgSlotCount | input | 10 | Number of channel slots per packet (1 to 512) |
| cfgStartCode | input | 8 | Start-code value |
| cfgBreakBits | input | 8 | Break length in bit times |
| cfgMabBits | input | 8 | Mark-after-break length in bit times |
| memWrEn | input | 1 | Channel store write strobe |
| memWrAddr | input | 9 | Channel store write address (0 = channel 1) |
| memWrData | input | 8 | Channel store write data |
| txOut | output | 1 | Serial line to the RS-485 driver, 1 = mark |

## Verification
The assertions assume that reset is applied once at start-up and that `CLK_PER_BIT` is at least 2. They also assume that the configuration inputs may change at any cycle, which the break-length and break-spacing checks tolerate because of the clamping. The stimulus writes the channel store only while no packet is in flight, so a slot never reads an entry that is being changed. It changes the configuration both between packets and in the middle of one. It drops `enable` only after a packet has begun.

// File: rtl/dmx_tx_pkg.sv
package dmx_tx_pkg;

  localparam int SLOT_BITS = 11;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_BREAK,
    MODE_MAB,
    MODE_SLOT,
    MODE_MBB
  } lineMode_e;

  // strobes from the sequencer to the serialiser
  typedef struct packed {
    logic      latchCfg;
    logic      loadStart;
    logic      loadChan;
    logic      shiftBit;
    lineMode_e mode;
  } txStrobe_t;

endpackage

// File: rtl/dmx_tx_ctrl.sv
module dmx_tx_ctrl
  import dmx_tx_pkg::*;
#(
  parameter int CLK_PER_BIT  = 200,
  parameter int MIN_BRK_BITS = 23,
  parameter int MIN_MAB_BITS = 2,
  parameter int MIN_PKT_BITS = 301,
  parameter int CHAN_COUNT   = 512
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            enable,
  input  logic [$clog2(CHAN_COUNT+1)-1:0] cfgSlotCount,
  input  logic [7:0]                      cfgBreakBits,
  input  logic [7:0]                      cfgMabBits,
  output txStrobe_t                       strobe,
  output logic [$clog2(CHAN_COUNT)-1:0]   rdAddr
);

  localparam int DIV_W  = $clog2(CLK_PER_BIT);
  localparam int SLOT_W = $clog2(CHAN_COUNT + 1);
  localparam int ADDR_W = $clog2(CHAN_COUNT);
  localparam int PKT_W  = 16;

  lineMode_e          mode;
  logic [DIV_W-1:0]   divCnt;
  logic [7:0]         bitCnt;
  logic [SLOT_W-1:0]  slotIdx;
  logic [SLOT_W-1:0]  slotTotal;
  logic [PKT_W-1:0]   pktBits;
  logic [7:0]         brkLen;
  logic [7:0]         mabLen;

  logic [7:0]         brkEff;
  logic [7:0]         mabEff;
  logic [SLOT_W-1:0]  slotEff;
  logic               tick;
  logic [PKT_W-1:0]   pktNext;
  logic               longEnough;
  logic               endBreak;
  logic               endMab;
  logic               endSlot;
  logic               lastSlot;
  logic               endPkt;
  logic               startPkt;

  // clamp the configuration to the protocol minimums and the store size
  always_comb begin
    brkEff = (cfgBreakBits < 8'(MIN_BRK_BITS)) ? 8'(MIN_BRK_BITS) : cfgBreakBits;
    mabEff = (cfgMabBits < 8'(MIN_MAB_BITS)) ? 8'(MIN_MAB_BITS) : cfgMabBits;
    if (cfgSlotCount == '0)
      slotEff = SLOT_W'(1);
    else if (cfgSlotCount > SLOT_W'(CHAN_COUNT))
      slotEff = SLOT_W'(CHAN_COUNT);
    else
      slotEff = cfgSlotCount;
  end

  always_comb begin
    tick       = (mode != MODE_IDLE) && (divCnt == DIV_W'(CLK_PER_BIT - 1));
    pktNext    = pktBits + PKT_W'(1);
    longEnough = pktNext >= PKT_W'(MIN_PKT_BITS);
    endBreak   = tick && (mode == MODE_BREAK) && (bitCnt == brkLen - 8'd1);
    endMab     = tick && (mode == MODE_MAB) && (bitCnt == mabLen - 8'd1);
    endSlot    = tick && (mode == MODE_SLOT) && (bitCnt == 8'(SLOT_BITS - 1));
    lastSlot   = slotIdx == slotTotal;
    endPkt     = (endSlot && lastSlot && longEnough) ||
                 (tick && (mode == MODE_MBB) && longEnough);
    startPkt   = ((mode == MODE_IDLE) || endPkt) && enable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= MODE_IDLE;
    end else begin
      unique case (mode)
        MODE_IDLE:  if (enable) mode <= MODE_BREAK;
        MODE_BREAK: if (endBreak) mode <= MODE_MAB;
        MODE_MAB:   if (endMab) mode <= MODE_SLOT;
        MODE_SLOT: begin
          if (endSlot && lastSlot) begin
            if (!longEnough)  mode <= MODE_MBB;
            else if (enable)  mode <= MODE_BREAK;
            else              mode <= MODE_IDLE;
          end
        end
        MODE_MBB: begin
          if (tick && longEnough) mode <= enable ? MODE_BREAK : MODE_IDLE;
        end
        default: mode <= MODE_IDLE;
      endcase
    end
  end

  // bit-time divider, realigned at every packet start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          divCnt <= '0;
    else if (startPkt || tick)          divCnt <= '0;
    else if (mode != MODE_IDLE)         divCnt <= divCnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          bitCnt <= '0;
    else if (startPkt || endBreak || endMab || endSlot) bitCnt <= '0;
    else if (tick)                                      bitCnt <= bitCnt + 8'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       slotIdx <= '0;
    else if (endMab)                 slotIdx <= '0;
    else if (endSlot && !lastSlot)   slotIdx <= slotIdx + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pktBits <= '0;
    else if (startPkt) pktBits <= '0;
    else if (tick)     pktBits <= pktNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkLen    <= 8'(MIN_BRK_BITS);
      mabLen    <= 8'(MIN_MAB_BITS);
      slotTotal <= SLOT_W'(1);
    end else if (startPkt) begin
      brkLen    <= brkEff;
      mabLen    <= mabEff;
      slotTotal <= slotEff;
    end
  end

  assign rdAddr = slotIdx[ADDR_W-1:0];

  always_comb begin
    strobe.latchCfg  = startPkt;
    strobe.loadStart = endMab;
    strobe.loadChan  = endSlot && !lastSlot;
    strobe.shiftBit  = tick && (mode == MODE_SLOT) && !endSlot;
    strobe.mode      = mode;
  end

endmodule

// File: rtl/dmx_tx_datapath.sv
module dmx_tx_datapath
  import dmx_tx_pkg::*;
#(
  parameter int CHAN_COUNT = 512
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  txStrobe_t                     strobe,
  input  logic [$clog2(CHAN_COUNT)-1:0] rdAddr,
  input  logic [7:0]                    cfgStartCode,
  input  logic                          memWrEn,
  input  logic [$clog2(CHAN_COUNT)-1:0] memWrAddr,
  input  logic [7:0]                    memWrData,
  output logic                          txOut
);

  logic [7:0]           chanMem [CHAN_COUNT];
  logic [7:0]           startCode;
  logic [SLOT_BITS-1:0] shiftReg;
  logic [7:0]           rdData;

  always_ff @(posedge clk) begin
    if (memWrEn && (32'(memWrAddr) < CHAN_COUNT)) chanMem[memWrAddr] <= memWrData;
  end

  assign rdData = chanMem[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                startCode <= '0;
    else if (strobe.latchCfg) startCode <= cfgStartCode;
  end

  // slot frame: stop bits high, data LSB first, start bit low at bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shiftReg <= '1;
    else if (strobe.loadStart) shiftReg <= {2'b11, startCode, 1'b0};
    else if (strobe.loadChan)  shiftReg <= {2'b11, rdData, 1'b0};
    else if (strobe.shiftBit)  shiftReg <= {1'b1, shiftReg[SLOT_BITS-1:1]};
  end

  always_comb begin
    unique case (strobe.mode)
      MODE_BREAK: txOut = 1'b0;
      MODE_SLOT:  txOut = shiftReg[0];
      default:    txOut = 1'b1;
    endcase
  end

endmodule

// File: rtl/dmx_packet_tx.sv
module dmx_packet_tx
  import dmx_tx_pkg::*;
#(
  parameter int CLK_PER_BIT  = 200,
  parameter int MIN_BRK_BITS = 23,
  parameter int MIN_MAB_BITS = 2,
  parameter int MIN_PKT_BITS = 301,
  parameter int CHAN_COUNT   = 512
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            enable,
  input  logic [$clog2(CHAN_COUNT+1)-1:0] cfgSlotCount,
  input  logic [7:0]                      cfgStartCode,
  input  logic [7:0]                      cfgBreakBits,
  input  logic [7:0]                      cfgMabBits,
  input  logic                            memWrEn,
  input  logic [$clog2(CHAN_COUNT)-1:0]   memWrAddr,
  input  logic [7:0]                      memWrData,
  output logic                            txOut
);

  localparam int ADDR_W = $clog2(CHAN_COUNT);

  txStrobe_t         ctrlStrobe;
  logic [ADDR_W-1:0] rdAddr;

  dmx_tx_ctrl #(
    .CLK_PER_BIT (CLK_PER_BIT),
    .MIN_BRK_BITS(MIN_BRK_BITS),
    .MIN_MAB_BITS(MIN_MAB_BITS),
    .MIN_PKT_BITS(MIN_PKT_BITS),
    .CHAN_COUNT  (CHAN_COUNT)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .cfgSlotCount(cfgSlotCount),
    .cfgBreakBits(cfgBreakBits),
    .cfgMabBits  (cfgMabBits),
    .strobe      (ctrlStrobe),
    .rdAddr      (rdAddr)
  );

  dmx_tx_datapath #(
    .CHAN_COUNT(CHAN_COUNT)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (ctrlStrobe),
    .rdAddr      (rdAddr),
    .cfgStartCode(cfgStartCode),
    .memWrEn     (memWrEn),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData),
    .txOut       (txOut)
  );

endmodule

// File: rtl/dmx_tx_checker.sv
module dmx_tx_checker
  import dmx_tx_pkg::*;
#(
  parameter int CLK_PER_BIT  = 200,
  parameter int MIN_BRK_BITS = 23,
  parameter int MIN_PKT_BITS = 301
) (
  input logic      clk,
  input logic      rstN,
  input logic      txOut,
  input txStrobe_t strobe
);

  logic [31:0] brkRun;
  logic [31:0] sinceBrk;
  logic        seenBrk;
  lineMode_e   prevMode;
  logic        newBrk;

  assign newBrk = (strobe.mode == MODE_BREAK) && (prevMode != MODE_BREAK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkRun   <= '0;
      sinceBrk <= '0;
      seenBrk  <= 1'b0;
      prevMode <= MODE_IDLE;
    end else begin
      prevMode <= strobe.mode;
      brkRun   <= (strobe.mode == MODE_BREAK) ? brkRun + 32'd1 : 32'd0;
      if (newBrk) begin
        sinceBrk <= 32'd1;
        seenBrk  <= 1'b1;
      end else if (sinceBrk != '1) begin
        sinceBrk <= sinceBrk + 32'd1;
      end
    end
  end

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == MODE_IDLE || strobe.mode == MODE_MBB) |-> txOut);

  p_break_space_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == MODE_BREAK) |-> !txOut);

  p_break_min_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == MODE_MAB && prevMode == MODE_BREAK) |->
      (brkRun >= 32'(MIN_BRK_BITS * CLK_PER_BIT)));

  p_mab_mark_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == MODE_MAB) |-> txOut);

  p_one_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadStart, strobe.loadChan, strobe.shiftBit}));

  p_load_in_slot_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadChan |-> (strobe.mode == MODE_SLOT));

  p_break_spacing_r7: assert property (@(posedge clk) disable iff (!rstN)
    (newBrk && seenBrk) |-> (sinceBrk >= 32'(MIN_PKT_BITS * CLK_PER_BIT)));

  p_latch_starts_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchCfg |=> (strobe.mode == MODE_BREAK));

endmodule

bind dmx_packet_tx dmx_tx_checker #(
  .CLK_PER_BIT (CLK_PER_BIT),
  .MIN_BRK_BITS(MIN_BRK_BITS),
  .MIN_PKT_BITS(MIN_PKT_BITS)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .txOut (txOut),
  .strobe(ctrlStrobe)
);

// File: tb/test_dmx_packet_tx.sv
module test_dmx_packet_tx;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 4;
  localparam int MIN_PKT    = 301;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [9:0] cfgSlotCount = 10'd3;
  logic [7:0] cfgStartCode = 8'h00;
  logic [7:0] cfgBreakBits = 8'd44;
  logic [7:0] cfgMabBits = 8'd3;
  logic       memWrEn = 1'b0;
  logic [8:0] memWrAddr = '0;
  logic [7:0] memWrData = '0;
  logic       txOut;

  dmx_packet_tx #(.CLK_PER_BIT(BIT_CLKS)) i_dmx_packet_tx (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgSlotCount(cfgSlotCount), .cfgStartCode(cfgStartCode),
    .cfgBreakBits(cfgBreakBits), .cfgMabBits(cfgMabBits),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .txOut(txOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  int    pktStarts = 0;
  bit    done = 1'b0;
  bit    expQ[$];
  string tagQ[$];
  bit    expLevel;
  string expTag;
  logic [7:0] refMem [512];

  task automatic pushLevel(input bit lvl, input int bits, input string tag);
    for (int i = 0; i < bits * BIT_CLKS; i++) begin
      expQ.push_back(lvl);
      tagQ.push_back(tag);
    end
  endtask

  // R4: start bit 0, data LSB first, two stop bits 1
  task automatic pushSlot(input logic [7:0] val, input string tag);
    pushLevel(1'b0, 1, tag);
    for (int b = 0; b < 8; b++) pushLevel(val[b], 1, tag);
    pushLevel(1'b1, 2, tag);
  endtask

  task automatic buildPacket();
    int n, brk, mab, total;
    n   = (cfgSlotCount == 0) ? 1 : ((cfgSlotCount > 512) ? 512 : int'(cfgSlotCount)); // R6
    brk = (cfgBreakBits < 23) ? 23 : int'(cfgBreakBits);
    mab = (cfgMabBits < 2) ? 2 : int'(cfgMabBits);
    pushLevel(1'b0, brk, "R2 break");
    pushLevel(1'b1, mab, "R3 mark-after-break");
    pushSlot(cfgStartCode, "R4 start code");
    for (int i = 0; i < n; i++) pushSlot(refMem[i], "R5 channel slot");
    total = brk + mab + 11 * (n + 1);
    if (total < MIN_PKT) pushLevel(1'b1, MIN_PKT - total, "R7 padding");
    pktStarts++;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // reference model and per-cycle comparison
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      expQ.delete();
      tagQ.delete();
      expLevel = 1'b1;
      expTag   = "R1 reset";
    end else begin
      if (memWrEn) refMem[memWrAddr] = memWrData;
      if (expQ.size() == 0 && enable) buildPacket(); // R8 capture, R9 back-to-back
      if (expQ.size() != 0) begin
        expLevel = expQ.pop_front();
        expTag   = tagQ.pop_front();
      end else begin
        expLevel = 1'b1;
        expTag   = "R1 idle";
      end
    end
    #(CLK_PERIOD / 4);
    checks++;
    if (txOut !== expLevel) begin
      errors++;
      $display("FAIL %s cycle %0d: txOut=%b expected=%b", expTag, cycles, txOut, expLevel);
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<=%0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  task automatic writeChan(input int addr, input logic [7:0] val);
    @(negedge clk);
    memWrEn   = 1'b1;
    memWrAddr = 9'(addr);
    memWrData = val;
    @(negedge clk);
    memWrEn = 1'b0;
  endtask

  task automatic setCfg(input int n, input logic [7:0] sc, input int brk, input int mab);
    @(negedge clk);
    cfgSlotCount = 10'(n);
    cfgStartCode = sc;
    cfgBreakBits = 8'(brk);
    cfgMabBits   = 8'(mab);
  endtask

  // R9: hold enable for the given number of packet starts, then drop it mid-packet
  task automatic runPackets(input int count);
    int target;
    target = pktStarts + count;
    @(negedge clk);
    enable = 1'b1;
    while (pktStarts < target) @(negedge clk);
    enable = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (10) @(negedge clk);          // R1 idle at mark with enable low

    for (int i = 0; i < 512; i++) writeChan(i, 8'((i * 37 + 5) & 255));

    // basic packet with padding
    setCfg(3, 8'h00, 44, 3);
    runPackets(1);

    // R6 zero count, R2 short break clamp, R3 short MAB clamp, nonzero start code
    setCfg(0, 8'hA5, 5, 0);
    runPackets(1);

    // R6 count above the store size, long packet without padding (R7)
    setCfg(600, 8'h00, 30, 4);
    runPackets(1);

    // R8: change configuration in the middle of the first of two packets
    setCfg(20, 8'h3C, 30, 4);
    @(negedge clk);
    enable = 1'b1;
    while (pktStarts == 0) @(negedge clk);
    begin
      int first;
      first = pktStarts;
      repeat (100) @(negedge clk);
      cfgSlotCount = 10'd2;
      cfgStartCode = 8'hC3;
      cfgBreakBits = 8'd60;
      while (pktStarts < first + 2) @(negedge clk);
    end
    enable = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);

    // R5 rewrite some channels while idle, then three back-to-back long packets (R9)
    writeChan(0, 8'h01);
    writeChan(1, 8'h80);
    writeChan(39, 8'hFF);
    setCfg(40, 8'h00, 23, 2);
    runPackets(3);

    finishRun();
  end

endmodule